// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is the receiving end of a three-wire, write-only configuration port. A host lowers the active-low select, then sends bits on the serial data line. Each bit is taken on a rising edge of the serial clock. After the 24th bit of a select pulse, the accumulated word is committed. Its leading byte selects a register and its trailing 16 bits become that register's new contents. Shorter bursts write nothing. Longer bursts keep only their first 24 bits.

A committed word crosses into the system clock domain through a toggle flag and a synchronizer. There it appears for one cycle on a write strobe with its address and data, and it updates a small register bank. The bank's addresses and reset values are parameters, and its contents are driven out in parallel for use by the rest of the chip.

The write strobe is valid-only and has no ready. The serial host cannot be stalled, so consumers of `wr_stb` must take each beat in the cycle it appears.

Top module: `sreg_serial_slave`

## Requirements
- R1: After system reset, `reg_out` holds each register's reset default. With the default parameters, the registers at addresses 0x10, 0x22, 0x37 and 0x4C reset to 0x0000, 0x1234, 0xFFFF and 0x0001, in slices 0 to 3 of `reg_out`. Slice i is bits [16*i+15:16*i].
- R2: A bit is captured only on a rising `sclk` edge while `csn` is low. `sclk` edges while `csn` is high have no effect, and changes of `sdata` between rising edges are not seen.
- R3: The first 8 bits of a select pulse form the address, MSB first. The next 16 bits form the data, MSB first. The word is committed on the 24th rising edge.
- R4: Bits after the 24th within one low period of `csn` are ignored.
- R5: Raising `csn` restarts the bit count. A pulse with fewer than 24 bits writes nothing and produces no strobe.
- R6: A committed word whose address matches a bank register replaces that register's value. A word with any other address leaves every register unchanged. A register changes only in the cycle after `wr_stb`.
- R7: Each committed word produces exactly one single-cycle `wr_stb`, carrying the word's address and data on `wr_addr` and `wr_data`. The strobe comes no later than 5 `clk` cycles after the 24th rising `sclk` edge, and the addressed register is updated within 6 cycles.
- R8: Operation does not depend on the `sclk` rate or duty cycle, from very slow edges up to a period of 50 ns, as long as `clk` is at least four times faster.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sclk | input | 1 | Serial clock from the host |
| csn | input | 1 | Active-low select; high clears the bit count |
| sdata | input | 1 | Serial data, MSB first |
| wr_stb | output | 1 | One-cycle strobe per committed word (valid-only) |
| wr_addr | output | 8 | Address of the committed word |
| wr_data | output | 16 | Data of the committed word |
| reg_out | output | NREG*16 | Register bank contents, register i in slice i |

## Verification
The strobe lags the 24th rising serial edge by two synchronizer flops, one edge-detect register and up to one cycle of sampling uncertainty. The register lags the strobe by exactly one more cycle. The bench reference model therefore opens a window at the 24th edge it drives. Inside that window each affected register may show either its old or its new value, and exactly one strobe with the expected address and data must appear. Once six cycles have passed, the window closes and the new value is mandatory. Outside any window, every register must match the model exactly and no strobe may appear, on every clock.

// File: rtl/sreg_pkg.sv
`timescale 1ns/1ps
package sreg_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 16;
  localparam int FRAME_W = ADDR_W + DATA_W;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } sreg_word_t;
endpackage

// File: rtl/sreg_frame_rx.sv
`timescale 1ns/1ps
// Serial-clock domain: counts bits in a select pulse, commits on the last one.
module sreg_frame_rx
  import sreg_pkg::*;
(
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       csn,
  input  logic       sdata,
  output sreg_word_t word_o,
  output logic       tog_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-2:0] shift_q;
  logic               clr;

  assign clr = csn | ~rst_n;

  // Count saturates at FRAME_W, so surplus bits find no slot.
  always_ff @(posedge sclk or posedge clr) begin
    if (clr)               cnt_q <= '0;
    else if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge sclk) begin
    if (!csn && cnt_q < LAST) shift_q <= {shift_q[FRAME_W-3:0], sdata};
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      word_o <= '0;
      tog_o  <= 1'b0;
    end else if (!csn && cnt_q == LAST) begin
      word_o <= {shift_q, sdata};
      tog_o  <= ~tog_o;
    end
  end
endmodule

// File: rtl/sreg_cdc_strobe.sv
`timescale 1ns/1ps
// System domain: synchronises the commit toggle and issues one strobe per flip.
module sreg_cdc_strobe
  import sreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tog_i,
  input  sreg_word_t word_i,
  output logic       stb_o,
  output sreg_word_t word_o
);
  logic [SYNC_STAGES:0] sync_q;
  logic                 flip;

  assign flip = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      stb_o  <= 1'b0;
      word_o <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-1:0], tog_i};
      stb_o  <= flip;
      // word_i has been stable for SYNC_STAGES cycles when flip is seen
      if (flip) word_o <= word_i;
    end
  end
endmodule

// File: rtl/sreg_bank.sv
`timescale 1ns/1ps
// Register bank with parameterised addresses and reset values.
module sreg_bank
  import sreg_pkg::*;
#(
  parameter int                       NREG      = 4,
  parameter logic [NREG*ADDR_W-1:0]   REG_ADDRS = '0,
  parameter logic [NREG*DATA_W-1:0]   REG_RESET = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     stb,
  input  sreg_word_t               word,
  output logic [NREG*DATA_W-1:0]   regs_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] MY_ADDR = REG_ADDRS[i*ADDR_W +: ADDR_W];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         regs_o[i*DATA_W +: DATA_W] <= REG_RESET[i*DATA_W +: DATA_W];
      else if (stb && word.addr == MY_ADDR) regs_o[i*DATA_W +: DATA_W] <= word.data;
    end
  end
endmodule

// File: rtl/sreg_serial_slave.sv
`timescale 1ns/1ps
module sreg_serial_slave
  import sreg_pkg::*;
#(
  parameter int                     NREG        = 4,
  parameter logic [NREG*ADDR_W-1:0] REG_ADDRS   = {8'h4C, 8'h37, 8'h22, 8'h10},
  parameter logic [NREG*DATA_W-1:0] REG_RESET   = {16'h0001, 16'hFFFF, 16'h1234, 16'h0000},
  parameter int                     SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sclk,
  input  logic                   csn,
  input  logic                   sdata,
  output logic                   wr_stb,
  output logic [ADDR_W-1:0]      wr_addr,
  output logic [DATA_W-1:0]      wr_data,
  output logic [NREG*DATA_W-1:0] reg_out
);
  sreg_word_t rx_word;
  sreg_word_t sys_word;
  logic       rx_tog;

  sreg_frame_rx u_rx (
    .rst_n (rst_n),
    .sclk  (sclk),
    .csn   (csn),
    .sdata (sdata),
    .word_o(rx_word),
    .tog_o (rx_tog)
  );

  sreg_cdc_strobe #(.SYNC_STAGES(SYNC_STAGES)) u_cdc (
    .clk   (clk),
    .rst_n (rst_n),
    .tog_i (rx_tog),
    .word_i(rx_word),
    .stb_o (wr_stb),
    .word_o(sys_word)
  );

  sreg_bank #(.NREG(NREG), .REG_ADDRS(REG_ADDRS), .REG_RESET(REG_RESET)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (wr_stb),
    .word  (sys_word),
    .regs_o(reg_out)
  );

  assign wr_addr = sys_word.addr;
  assign wr_data = sys_word.data;
endmodule

// File: rtl/sreg_serial_slave_chk.sv
`timescale 1ns/1ps
module sreg_serial_slave_chk
  import sreg_pkg::*;
#(
  parameter int                     NREG      = 4,
  parameter logic [NREG*ADDR_W-1:0] REG_ADDRS = '0,
  parameter logic [NREG*DATA_W-1:0] REG_RESET = '0
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_stb,
  input logic [ADDR_W-1:0]      wr_addr,
  input logic [DATA_W-1:0]      wr_data,
  input logic [NREG*DATA_W-1:0] reg_out
);
  function automatic logic mapped(input logic [ADDR_W-1:0] a);
    logic hit = 1'b0;
    for (int k = 0; k < NREG; k++)
      if (REG_ADDRS[k*ADDR_W +: ADDR_W] == a) hit = 1'b1;
    return hit;
  endfunction

  assert_reset_defaults_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> reg_out == REG_RESET)
    else $error("reg_out differs from reset defaults");

  assert_strobe_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb)
    else $error("wr_stb held longer than one cycle");

  assert_change_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_out) |-> $past(wr_stb))
    else $error("register changed without a strobe");

  assert_unmapped_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !mapped(wr_addr)) |=> $stable(reg_out))
    else $error("write to unmapped address changed the bank");

  for (genvar i = 0; i < NREG; i++) begin : g_chk
    assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wr_addr == REG_ADDRS[i*ADDR_W +: ADDR_W])
        |=> reg_out[i*DATA_W +: DATA_W] == $past(wr_data))
      else $error("mapped write did not land in register %0d", i);
  end
endmodule

bind sreg_serial_slave sreg_serial_slave_chk #(
  .NREG(NREG), .REG_ADDRS(REG_ADDRS), .REG_RESET(REG_RESET)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
  .wr_data(wr_data), .reg_out(reg_out)
);

// File: tb/sreg_serial_slave_test.sv
`timescale 1ns/1ps
module sreg_serial_slave_test;
  localparam int NREG = 4;
  localparam int LAT_MAX = 6;
  localparam logic [7:0]  ADDRS [NREG] = '{8'h10, 8'h22, 8'h37, 8'h4C};
  localparam logic [15:0] DEFS  [NREG] = '{16'h0000, 16'h1234, 16'hFFFF, 16'h0001};

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, csn = 1'b1, sdata = 1'b0;
  logic        wr_stb;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;
  logic [NREG*16-1:0] reg_out;

  always #2 clk = ~clk;

  sreg_serial_slave uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .csn(csn), .sdata(sdata),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .reg_out(reg_out)
  );

  int checks = 0, fails = 0;
  bit running = 0, done = 0;
  string cur_req = "R1";

  logic [15:0] exp_r [NREG];
  bit          pend = 0, pend_hit = 0;
  int          pend_idx = 0, age = 0, strobes = 0;
  logic [7:0]  pend_addr;
  logic [15:0] pend_data;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Reference model: expected write opened at the 24th edge the bench drives.
  task automatic model_commit(input logic [23:0] w);
    pend_addr = w[23:16];
    pend_data = w[15:0];
    pend_hit  = 0;
    for (int k = 0; k < NREG; k++)
      if (ADDRS[k] == pend_addr) begin pend_hit = 1; pend_idx = k; end
    age = 0; strobes = 0; pend = 1;
  endtask

  always @(negedge clk) begin
    if (running) begin
      if (pend) begin
        age++;
        if (wr_stb) begin
          strobes++;
          chk(wr_addr == pend_addr && wr_data == pend_data, "R7", "strobe payload",
              {wr_addr, wr_data}, {pend_addr, pend_data});
        end
        if (age > LAT_MAX) begin
          chk(strobes == 1, "R7", "strobes per frame", strobes, 1);
          if (pend_hit) exp_r[pend_idx] = pend_data;
          pend = 0;
        end
      end else begin
        chk(!wr_stb, cur_req, "strobe without a frame", wr_stb, 0);
      end
      for (int i = 0; i < NREG; i++) begin
        if (pend && pend_hit && i == pend_idx)
          chk(reg_out[i*16 +: 16] == exp_r[i] || reg_out[i*16 +: 16] == pend_data,
              cur_req, "register in window", reg_out[i*16 +: 16], pend_data);
        else
          chk(reg_out[i*16 +: 16] == exp_r[i], cur_req, "register value",
              reg_out[i*16 +: 16], exp_r[i]);
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends n bits MSB first from bits[n-1]; optionally flips sdata mid-high.
  task automatic send(input logic [63:0] bits, input int n, input int hi,
                      input int lo, input bit flip);
    wait_clk(1);
    csn = 1'b0;
    for (int i = 0; i < n; i++) begin
      sdata = bits[n-1-i];
      wait_clk(lo);
      sclk = 1'b1;
      if (i == 23) model_commit(bits[n-1 -: 24]);
      if (flip) begin
        wait_clk(hi / 2);
        sdata = ~sdata;
        wait_clk(hi - hi / 2);
      end else wait_clk(hi);
      sclk = 1'b0;
    end
    wait_clk(lo);
    csn = 1'b1;
    wait_clk(LAT_MAX + 6);
  endtask

  task automatic check_reg(input int idx, input logic [15:0] v, input string req);
    chk(reg_out[idx*16 +: 16] == v, req, "register after frame", reg_out[idx*16 +: 16], v);
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) exp_r[i] = DEFS[i];
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(1);
    // R1: reset defaults and idle strobe
    for (int i = 0; i < NREG; i++) check_reg(i, DEFS[i], "R1");
    chk(!wr_stb, "R1", "strobe after reset", wr_stb, 0);
    running = 1;
    wait_clk(3);

    // R3: address then data, both MSB first
    cur_req = "R3";
    send({40'h0, 8'h10, 16'hA5C3}, 24, 7, 7, 0);
    check_reg(0, 16'hA5C3, "R3");
    send({40'h0, 8'h4C, 16'h8001}, 24, 7, 7, 0);
    check_reg(3, 16'h8001, "R3");

    // R6: unmapped address leaves the bank alone
    cur_req = "R6";
    send({40'h0, 8'h11, 16'hDEAD}, 24, 7, 7, 0);
    for (int i = 0; i < NREG; i++) check_reg(i, exp_r[i], "R6");

    // R5: short pulse dropped, next full pulse counts from zero
    cur_req = "R5";
    send({54'h0, 10'h3FF}, 10, 7, 7, 0);
    check_reg(1, 16'h1234, "R5");
    send({40'h0, 8'h22, 16'h0F0F}, 24, 7, 7, 0);
    check_reg(1, 16'h0F0F, "R5");

    // R4: six surplus ones after the word are ignored
    cur_req = "R4";
    send({34'h0, 8'h37, 16'h5A5A, 6'h3F}, 30, 7, 7, 0);
    check_reg(2, 16'h5A5A, "R4");

    // R2: edges while deselected, and data changes while sclk is high
    cur_req = "R2";
    for (int i = 0; i < 30; i++) begin
      sdata = 1'($urandom);
      wait_clk(4); sclk = 1'b1; wait_clk(4); sclk = 1'b0;
    end
    wait_clk(LAT_MAX + 4);
    for (int i = 0; i < NREG; i++) check_reg(i, exp_r[i], "R2");
    send({40'h0, 8'h10, 16'h3C96}, 24, 7, 7, 1);
    check_reg(0, 16'h3C96, "R2");

    // R8: very slow, lopsided serial clocks in both directions
    cur_req = "R8";
    send({40'h0, 8'h4C, 16'h7E81}, 24, 2, 150, 0);
    check_reg(3, 16'h7E81, "R8");
    send({40'h0, 8'h22, 16'hC3A5}, 24, 90, 4, 0);
    check_reg(1, 16'hC3A5, "R8");

    running = 0;
    done = 1;
    summary();
    $finish;
  end
endmodule